// File: doc/BRIEF.md
# Standard Event Register with Power-On Control

This block gathers one-cycle event pulses into a bank of sticky bits. A mask register selects which of those bits may raise a single summary output, which feeds the event summary position (bit 5) of a status byte elsewhere. A controller reads the sticky bits through a read-and-clear strobe. It can also empty them with a plain clear strobe, rewrite the mask at any time, and set a power-on-clear flag.

Two reset inputs exist. `nv_init` initialises everything, including the power-on-clear flag, which models nonvolatile storage. `por` models the unit powering up. On a power-up the power-on event bit (bit 7) is set by itself, the other event bits are dropped, and the mask is either kept or cleared depending on the flag. A typical use keeps the mask across power-up so that an unexpected loss of power raises the summary. To do this, software turns the flag off and writes 128 to the mask.

Top module: `sev_event_status`

## Requirements
- R1: While `nv_init` is high, at the next edge the power-on-clear flag takes the value of parameter POC_DEFAULT (1), and the mask, the event bits, `rd_data` and `summary` all become zero. `nv_init` overrides every other input.
- R2: A high bit i of `evt_pulse` sets event bit i at the next edge. The bit then stays set until a read, a clear, a power-up or an initialisation.
- R3: With `rd` high, `rd_data` shows, after the next edge, the event bits held before that edge, and the event bits are cleared. Without `rd`, `rd_data` holds its value.
- R4: An event pulse in the same cycle as `rd` or `clr` leaves its bit set after the edge.
- R5: `clr` empties the event bits without changing the mask, the flag or `rd_data`.
- R6: With `por` high (and `nv_init` low), the event bits become exactly 0x80 (bit 7 only). Event pulses, reads, clears and mask writes in that cycle are ignored, and `rd_data` becomes zero.
- R7: On `por`, the mask is cleared if the flag is 1 and kept if the flag is 0. The flag itself is unchanged by `por`.
- R8: With `en_wr` high, the mask takes `en_wdata` at the next edge. Any pattern is accepted; 0x80 enables only the power-on bit.
- R9: After each edge, `summary` equals the OR of the bitwise AND of the event bits and the mask held after that same edge.
- R10: With `poc_wr` high, the flag takes `poc_wdata` at the next edge. Only `poc_wr` and `nv_init` change the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| nv_init | input | 1 | Synchronous initialisation of all state, including the flag |
| por | input | 1 | Synchronous power-up event |
| clr | input | 1 | Clear event bits |
| rd | input | 1 | Read and clear event bits |
| evt_pulse | input | EVT_W | One-cycle event pulses |
| en_wr | input | 1 | Mask write strobe |
| en_wdata | input | EVT_W | Mask write value |
| poc_wr | input | 1 | Power-on-clear flag write strobe |
| poc_wdata | input | 1 | Power-on-clear flag write value |
| rd_data | output | EVT_W | Event bits captured by the last read |
| en_mask | output | EVT_W | Current mask |
| poc_flag | output | 1 | Current power-on-clear flag |
| summary | output | 1 | OR of enabled event bits |

## Verification
The assertions assume that `nv_init` is asserted before the first check. They also assume that a cycle carrying `por` is meant to discard every other request, so they only judge pulse retention and write effects in cycles without a power-up. The stimulus opens with an initialisation and then follows directed sequences. These cover power-up with each flag value, and reads and clears that collide with pulses. A random phase follows in which `por` is rare and `nv_init` is never raised again. A behavioural model compares all four outputs after every edge.

// File: rtl/sev_pkg.sv
package sev_pkg;
  typedef enum logic [1:0] {
    EV_HOLD    = 2'd0,
    EV_CLEAR   = 2'd1,
    EV_POWERUP = 2'd2,
    EV_INIT    = 2'd3
  } ev_op_e;
endpackage

// File: rtl/sev_evt_latch.sv
module sev_evt_latch
  import sev_pkg::*;
#(
  parameter int EVT_W   = 8,
  parameter int PON_BIT = 7
) (
  input  logic             clk,
  input  logic             nv_init,
  input  ev_op_e           op,
  input  logic             rd,
  input  logic [EVT_W-1:0] pulse,
  output logic [EVT_W-1:0] ev_q,
  output logic [EVT_W-1:0] ev_nxt,
  output logic [EVT_W-1:0] rd_data
);
  localparam logic [EVT_W-1:0] PON_MASK = EVT_W'(1) << PON_BIT;

  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    always_comb begin
      unique case (op)
        EV_INIT:    ev_nxt[i] = 1'b0;
        EV_POWERUP: ev_nxt[i] = PON_MASK[i];
        EV_CLEAR:   ev_nxt[i] = pulse[i];
        default:    ev_nxt[i] = ev_q[i] | pulse[i];
      endcase
    end
    always_ff @(posedge clk) ev_q[i] <= ev_nxt[i];
  end

  always_ff @(posedge clk) begin
    if (op == EV_INIT || op == EV_POWERUP) rd_data <= '0;
    else if (rd)                           rd_data <= ev_q;
  end

  AST_PON_ONLY: assert property (@(posedge clk) disable iff (nv_init)
    (op == EV_POWERUP) |=> (ev_q == PON_MASK)); // R6
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (nv_init)
    (op == EV_HOLD) |=> ((ev_q & $past(ev_q)) == $past(ev_q))); // R2
  AST_PULSE_KEPT: assert property (@(posedge clk) disable iff (nv_init)
    (op == EV_HOLD || op == EV_CLEAR) |=> ((ev_q & $past(pulse)) == $past(pulse))); // R4
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (nv_init)
    (rd && op != EV_POWERUP) |=> (rd_data == $past(ev_q))); // R3
endmodule

// File: rtl/sev_enable_ctl.sv
module sev_enable_ctl
  import sev_pkg::*;
#(
  parameter int   EVT_W       = 8,
  parameter logic POC_DEFAULT = 1'b1
) (
  input  logic             clk,
  input  logic             nv_init,
  input  ev_op_e           op,
  input  logic             en_wr,
  input  logic [EVT_W-1:0] en_wdata,
  input  logic             poc_wr,
  input  logic             poc_wdata,
  output logic [EVT_W-1:0] en_q,
  output logic [EVT_W-1:0] en_nxt,
  output logic             flag_q
);
  logic flag_nxt;

  always_comb begin
    en_nxt   = en_q;
    flag_nxt = flag_q;
    unique case (op)
      EV_INIT: begin
        en_nxt   = '0;
        flag_nxt = POC_DEFAULT;
      end
      EV_POWERUP: begin
        if (flag_q) en_nxt = '0;
      end
      default: begin
        if (en_wr)  en_nxt   = en_wdata;
        if (poc_wr) flag_nxt = poc_wdata;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    en_q   <= en_nxt;
    flag_q <= flag_nxt;
  end

  AST_POR_CLEARS_MASK: assert property (@(posedge clk) disable iff (nv_init)
    (op == EV_POWERUP && flag_q) |=> (en_q == '0)); // R7
  AST_POR_KEEPS_MASK: assert property (@(posedge clk) disable iff (nv_init)
    (op == EV_POWERUP && !flag_q) |=> $stable(en_q)); // R7
  AST_FLAG_STABLE: assert property (@(posedge clk) disable iff (nv_init)
    (!poc_wr || op == EV_POWERUP) |=> $stable(flag_q)); // R10
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (nv_init)
    (en_wr && op != EV_POWERUP) |=> (en_q == $past(en_wdata))); // R8
endmodule

// File: rtl/sev_summary.sv
module sev_summary
  import sev_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             nv_init,
  input  ev_op_e           op,
  input  logic [EVT_W-1:0] ev_nxt,
  input  logic [EVT_W-1:0] en_nxt,
  input  logic [EVT_W-1:0] ev_q,
  input  logic [EVT_W-1:0] en_q,
  output logic             sum_q
);
  always_ff @(posedge clk) begin
    if (op == EV_INIT) sum_q <= 1'b0;
    else               sum_q <= |(ev_nxt & en_nxt);
  end

  AST_SUMMARY_MATCH: assert property (@(posedge clk) disable iff (nv_init)
    (op != EV_INIT) |=> (sum_q == |(ev_q & en_q))); // R9
endmodule

// File: rtl/sev_event_status.sv
module sev_event_status
  import sev_pkg::*;
#(
  parameter int   EVT_W       = 8,
  parameter int   PON_BIT     = 7,
  parameter logic POC_DEFAULT = 1'b1
) (
  input  logic             clk,
  input  logic             nv_init,
  input  logic             por,
  input  logic             clr,
  input  logic             rd,
  input  logic [EVT_W-1:0] evt_pulse,
  input  logic             en_wr,
  input  logic [EVT_W-1:0] en_wdata,
  input  logic             poc_wr,
  input  logic             poc_wdata,
  output logic [EVT_W-1:0] rd_data,
  output logic [EVT_W-1:0] en_mask,
  output logic             poc_flag,
  output logic             summary
);
  ev_op_e           op;
  logic [EVT_W-1:0] ev_q, ev_nxt, en_nxt;

  always_comb begin
    if (nv_init)        op = EV_INIT;
    else if (por)       op = EV_POWERUP;
    else if (clr || rd) op = EV_CLEAR;
    else                op = EV_HOLD;
  end

  sev_evt_latch #(.EVT_W(EVT_W), .PON_BIT(PON_BIT)) u_evt (
    .clk(clk), .nv_init(nv_init), .op(op), .rd(rd), .pulse(evt_pulse),
    .ev_q(ev_q), .ev_nxt(ev_nxt), .rd_data(rd_data)
  );

  sev_enable_ctl #(.EVT_W(EVT_W), .POC_DEFAULT(POC_DEFAULT)) u_en (
    .clk(clk), .nv_init(nv_init), .op(op), .en_wr(en_wr), .en_wdata(en_wdata),
    .poc_wr(poc_wr), .poc_wdata(poc_wdata),
    .en_q(en_mask), .en_nxt(en_nxt), .flag_q(poc_flag)
  );

  sev_summary #(.EVT_W(EVT_W)) u_sum (
    .clk(clk), .nv_init(nv_init), .op(op), .ev_nxt(ev_nxt), .en_nxt(en_nxt),
    .ev_q(ev_q), .en_q(en_mask), .sum_q(summary)
  );

  AST_INIT_CLEARS: assert property (@(posedge clk)
    nv_init |=> (en_mask == '0 && rd_data == '0 && !summary)); // R1
  AST_CLEAR_KEEPS_MASK: assert property (@(posedge clk) disable iff (nv_init)
    (clr && !por && !en_wr) |=> $stable(en_mask)); // R5
endmodule

// File: tb/tb_sev_event_status.sv
`timescale 1ns/1ps
module tb_sev_event_status;
  localparam int W = 8;

  logic clk = 1'b0;
  logic nv_init = 1'b0, por = 1'b0, clr = 1'b0, rd = 1'b0;
  logic [W-1:0] evt_pulse = '0, en_wdata = '0;
  logic en_wr = 1'b0, poc_wr = 1'b0, poc_wdata = 1'b0;
  logic [W-1:0] rd_data, en_mask;
  logic poc_flag, summary;

  int checks = 0, errors = 0;
  int m_ev = 0, m_en = 0, m_rd = 0, m_flag = 0;

  always #2 clk = ~clk;

  sev_event_status dut (
    .clk(clk), .nv_init(nv_init), .por(por), .clr(clr), .rd(rd),
    .evt_pulse(evt_pulse), .en_wr(en_wr), .en_wdata(en_wdata),
    .poc_wr(poc_wr), .poc_wdata(poc_wdata),
    .rd_data(rd_data), .en_mask(en_mask), .poc_flag(poc_flag), .summary(summary)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Drive one cycle, advance the model, compare all outputs after the edge.
  task automatic step(string tag);
    int ev, en, rdv, fl;
    ev = m_ev; en = m_en; rdv = m_rd; fl = m_flag;
    if (nv_init) begin
      ev = 0; en = 0; rdv = 0; fl = 1;
    end else if (por) begin
      ev = 'h80; rdv = 0;
      if (m_flag != 0) en = 0;
    end else begin
      if (rd) rdv = m_ev;
      if (rd || clr) ev = 0;
      ev = ev | int'(evt_pulse);
      if (en_wr) en = int'(en_wdata);
      if (poc_wr) fl = int'(poc_wdata);
    end
    m_ev = ev; m_en = en; m_rd = rdv; m_flag = fl;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " rd_data"}, int'(rd_data), m_rd);
    chk({tag, " en_mask"}, int'(en_mask), m_en);
    chk({tag, " poc_flag"}, int'(poc_flag), m_flag);
    chk({tag, " summary R9"}, int'(summary), ((m_ev & m_en) != 0) ? 1 : 0);
    nv_init = 0; por = 0; clr = 0; rd = 0; evt_pulse = '0;
    en_wr = 0; poc_wr = 0;
  endtask

  initial begin : watchdog
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    nv_init = 1; step("R1 init");
    nv_init = 1; evt_pulse = 8'hFF; en_wr = 1; en_wdata = 8'hFF; step("R1 init dominates");
    evt_pulse = 8'h08; step("R2 set bit3");
    step("R2 hold");
    rd = 1; step("R3 read");
    chk("R3 value", int'(rd_data), 'h08);
    rd = 1; step("R3 reread empty");
    en_wr = 1; en_wdata = 8'h08; step("R8 mask write");
    evt_pulse = 8'h08; step("R9 summary up");
    rd = 1; evt_pulse = 8'h08; step("R4 read+pulse");
    clr = 1; step("R5 clear");
    evt_pulse = 8'h04; clr = 1; step("R4 clear+pulse");
    por = 1; evt_pulse = 8'h01; step("R7 por flag1");
    chk("R7 mask cleared", int'(en_mask), 0);
    rd = 1; step("R6 read pon");
    chk("R6 pon only", int'(rd_data), 'h80);
    poc_wr = 1; poc_wdata = 0; step("R10 flag off");
    en_wr = 1; en_wdata = 8'h80; step("R8 mask 0x80");
    por = 1; evt_pulse = 8'h01; clr = 1; step("R7 por flag0");
    chk("R7 mask kept", int'(en_mask), 'h80);
    chk("R6 summary pon", int'(summary), 1);
    rd = 1; step("R6 pulses ignored");
    chk("R6 read 0x80", int'(rd_data), 'h80);
    for (int n = 0; n < 400; n++) begin
      evt_pulse = W'($urandom);
      rd = ($urandom % 4) == 0;
      clr = ($urandom % 8) == 0;
      en_wr = ($urandom % 6) == 0;
      en_wdata = W'($urandom);
      poc_wr = ($urandom % 10) == 0;
      poc_wdata = 1'($urandom);
      por = ($urandom % 25) == 0;
      step("R2 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule